// File: doc/BRIEF.md
# Trace Message Output Port

This block takes debug trace messages, each supplied as a run of packets, and sends them out over a narrow message-data bus. A packet arrives on a ready/valid interface with its bit length, a flag that marks it as variable-length, and a flag that marks it as the final packet of its message. The block cuts each packet into bus-width beats, least-significant bit first. It drives a message clock output at half the core clock rate. Data and a two-bit framing code change only on the falling edge of that clock, so an external tool can capture both on the rising edge.

The framing code lets the tool find the boundaries. One code marks the first beat of a message, one marks the end of a variable-length packet, and one marks the end of a message. Between messages the port drives an idle pattern. A configuration input selects either a 4-bit bus or the full 12-bit bus. The selection is taken for each packet when the block accepts it. After power-on reset, bit 0 of the data bus stays high until a clock-lock input reports lock. The producer is expected to offer the packets of one message back to back.

Top module: `trace_msg_port`

## Requirements
- R1: While reset is applied, and afterwards until `clk_locked` has been seen high, `mdo` is 12'h001 (bit 0 high, all other bits low), `mseo` is 2'b11, `mcko` is low and `pkt_ready` is low.
- R2: Once lock is seen, `mcko` toggles on every core clock edge. `mdo` and `mseo` change only on edges where `mcko` falls, so both are stable at every rising edge of `mcko`.
- R3: With `cfg_wide`=1 a beat carries 12 packet bits on `mdo[11:0]`. With `cfg_wide`=0 a beat carries 4 bits on `mdo[3:0]`, and `mdo[11:4]` is zero. `cfg_wide` is sampled when the packet is accepted.
- R4: Packet bits go out least-significant first. Bits at or above `pkt_len` are ignored. A final beat that is only partly filled is padded with zeros.
- R5: For a variable packet (`pkt_var`=1), beats are sent only up to the highest set bit below `pkt_len`. A variable packet whose value is zero is sent as a single zero beat.
- R6: `mseo` encoding per beat: 2'b00 on the first beat of a message; 2'b11 on the last beat of the final packet; 2'b01 on the last beat of any other variable packet; 2'b10 on every other beat.
- R7: If the first packet of a message fits in one beat and is variable or final, its end marker (2'b01 or 2'b11) is sent on one extra beat with all-zero data, placed right after the start beat.
- R8: After a beat coded 2'b11 that ends a message, at least one idle beat follows. Every 2'b00 beat is therefore preceded by at least two consecutive 2'b11 beats.
- R9: When no message is in progress, `mdo` is zero and `mseo` is 2'b11.
- R10: `pkt_ready` goes low in the cycle after a packet is accepted. It stays low until the packet's last beat has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| clk_locked | input | 1 | Clock-lock indication; the first high level starts the port |
| cfg_wide | input | 1 | 1 selects the 12-bit bus, 0 selects the 4-bit bus |
| pkt_valid | input | 1 | Packet offered |
| pkt_data | input | PKT_W | Packet bits, LSB first |
| pkt_len | input | clog2(PKT_W+1) | Packet length in bits (1..PKT_W) |
| pkt_var | input | 1 | Packet is variable-length (leading zeros trimmed) |
| pkt_last | input | 1 | Packet is the final packet of its message |
| pkt_ready | output | 1 | Block can accept a packet |
| mcko | output | 1 | Message clock output, half the core clock rate |
| mdo | output | BUS_W | Message data out |
| mseo | output | 2 | Message start/end framing code |

## Verification
The bench builds the block with its defaults: 32-bit packets, a 12-bit full bus and a 4-bit reduced bus. With these values, one packet spans up to eight narrow beats and up to three wide beats. Packets of 6, 12, 20 and 24 bits exercise padding, exact fills and trimming in both modes. Single-beat first packets trigger the extra marker beat, and back-to-back packets test the ready hand-off between packets.

// File: rtl/trace_port_pkg.sv
package trace_port_pkg;

  typedef enum logic [1:0] {
    FR_START   = 2'b00,
    FR_VAR_END = 2'b01,
    FR_BODY    = 2'b10,
    FR_END     = 2'b11
  } frame_e;

  // Number of significant bits in a value; a zero value still occupies one bit.
  function automatic int sig_bits(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 64; i++) if (v[i]) r = i + 1;
    return (r == 0) ? 1 : r;
  endfunction

  // Beats needed to carry a given number of bits on a bus of the given width.
  function automatic int beat_count(input int bits, input int width);
    return (bits + width - 1) / width;
  endfunction

endpackage

// File: rtl/trace_beat_slicer.sv
module trace_beat_slicer
  import trace_port_pkg::*;
#(
  parameter int PKT_W = 32,
  parameter int BUS_W = 12,
  parameter int NAR_W = 4,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_wide,
  input  logic             in_valid,
  input  logic [PKT_W-1:0] in_data,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_var,
  input  logic             in_last,
  output logic             in_ready,
  input  logic             take,
  output logic             hold_v,
  output logic [BUS_W-1:0] beat_data,
  output logic             beat_end,
  output logic             beat_var,
  output logic             beat_last
);

  logic [PKT_W-1:0] len_mask, masked, sh_q;
  logic [LEN_W-1:0] left_q;
  logic             hold_q, wide_q, var_q, last_q;
  logic             accept;
  int               eff_bits, nbeats;

  for (genvar i = 0; i < PKT_W; i++) begin : g_mask
    assign len_mask[i] = (LEN_W'(i) < in_len);
  end
  assign masked = in_data & len_mask;

  always_comb begin
    if (in_var) eff_bits = sig_bits(64'(masked));
    else        eff_bits = (in_len == '0) ? 1 : int'(in_len);
    nbeats = beat_count(eff_bits, cfg_wide ? BUS_W : NAR_W);
  end

  assign in_ready = run && !hold_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      hold_q <= 1'b0;
      wide_q <= 1'b0;
      var_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (take) begin
      sh_q   <= wide_q ? (sh_q >> BUS_W) : (sh_q >> NAR_W);
      left_q <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) hold_q <= 1'b0;
    end else if (accept) begin
      sh_q   <= masked;
      left_q <= LEN_W'(nbeats);
      hold_q <= 1'b1;
      wide_q <= cfg_wide;
      var_q  <= in_var;
      last_q <= in_last;
    end
  end

  assign hold_v    = hold_q;
  assign beat_data = wide_q ? sh_q[BUS_W-1:0] : {{(BUS_W-NAR_W){1'b0}}, sh_q[NAR_W-1:0]};
  assign beat_end  = (left_q == LEN_W'(1));
  assign beat_var  = var_q;
  assign beat_last = last_q;

  assert_take_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_q);
  assert_ready_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  assert_beats_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (left_q != '0));

endmodule

// File: rtl/trace_frame_ctrl.sv
module trace_frame_ctrl
  import trace_port_pkg::*;
#(
  parameter int BUS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             hold_v,
  input  logic [BUS_W-1:0] beat_data,
  input  logic             beat_end,
  input  logic             beat_var,
  input  logic             beat_last,
  output logic             take,
  output logic [BUS_W-1:0] mdo_q,
  output frame_e           mseo_q
);

  logic   in_msg_q, mark_q, gap_q, need_mark;
  frame_e mark_code_q, code, prev2_q;

  assign take      = upd && !mark_q && !gap_q && hold_v;
  assign need_mark = !in_msg_q && beat_end && (beat_var || beat_last);

  always_comb begin
    if (!in_msg_q)                  code = FR_START;
    else if (beat_end && beat_last) code = FR_END;
    else if (beat_end && beat_var)  code = FR_VAR_END;
    else                            code = FR_BODY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdo_q       <= '0;
      mseo_q      <= FR_END;
      prev2_q     <= FR_END;
      in_msg_q    <= 1'b0;
      mark_q      <= 1'b0;
      mark_code_q <= FR_END;
      gap_q       <= 1'b0;
    end else if (upd) begin
      prev2_q <= mseo_q;
      if (mark_q) begin
        mdo_q  <= '0;
        mseo_q <= mark_code_q;
        mark_q <= 1'b0;
        gap_q  <= (mark_code_q == FR_END);
      end else if (gap_q) begin
        mdo_q  <= '0;
        mseo_q <= FR_END;
        gap_q  <= 1'b0;
      end else if (hold_v) begin
        mdo_q    <= beat_data;
        mseo_q   <= code;
        in_msg_q <= !(beat_end && beat_last);
        if (need_mark) begin
          mark_q      <= 1'b1;
          mark_code_q <= beat_last ? FR_END : FR_VAR_END;
        end else if (beat_end && beat_last) begin
          gap_q <= 1'b1;
        end
      end else begin
        mdo_q  <= '0;
        mseo_q <= FR_END;
      end
    end
  end

  assert_gap_before_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_msg_q) |-> (mseo_q == FR_END && prev2_q == FR_END));
  assert_mark_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |-> (mseo_q == FR_START));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !hold_v && !mark_q && !gap_q) |=> (mdo_q == '0 && mseo_q == FR_END));

endmodule

// File: rtl/trace_msg_port.sv
module trace_msg_port
  import trace_port_pkg::*;
#(
  parameter  int PKT_W = 32,
  parameter  int BUS_W = 12,
  parameter  int NAR_W = 4,
  localparam int LEN_W = $clog2(PKT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_locked,
  input  logic             cfg_wide,
  input  logic             pkt_valid,
  input  logic [PKT_W-1:0] pkt_data,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             pkt_var,
  input  logic             pkt_last,
  output logic             pkt_ready,
  output logic             mcko,
  output logic [BUS_W-1:0] mdo,
  output logic [1:0]       mseo
);

  logic             run_q, mcko_q, upd, take, hold_v;
  logic             beat_end, beat_var, beat_last;
  logic [BUS_W-1:0] beat_data, mdo_q;
  frame_e           mseo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mcko_q <= 1'b0;
    end else begin
      if (clk_locked) run_q <= 1'b1;
      mcko_q <= run_q ? !mcko_q : 1'b0;
    end
  end

  // Beat update event: the edge on which the message clock falls.
  assign upd = run_q && mcko_q;

  trace_beat_slicer #(.PKT_W(PKT_W), .BUS_W(BUS_W), .NAR_W(NAR_W), .LEN_W(LEN_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cfg_wide(cfg_wide),
    .in_valid(pkt_valid), .in_data(pkt_data), .in_len(pkt_len), .in_var(pkt_var),
    .in_last(pkt_last), .in_ready(pkt_ready), .take(take), .hold_v(hold_v),
    .beat_data(beat_data), .beat_end(beat_end), .beat_var(beat_var), .beat_last(beat_last)
  );

  trace_frame_ctrl #(.BUS_W(BUS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .upd(upd), .hold_v(hold_v), .beat_data(beat_data),
    .beat_end(beat_end), .beat_var(beat_var), .beat_last(beat_last), .take(take),
    .mdo_q(mdo_q), .mseo_q(mseo_q)
  );

  assign mcko = mcko_q;
  assign mdo  = run_q ? mdo_q : BUS_W'(1);
  assign mseo = mseo_q;

  assert_hold_until_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (mdo == BUS_W'(1) && !mcko && !pkt_ready && mseo == 2'b11));
  assert_stable_off_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !upd) |=> ($stable(mdo) && $stable(mseo)));
  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (mcko != $past(mcko)));

endmodule

// File: tb/tb_trace_msg_port.sv
module tb_trace_msg_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_locked = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [31:0] pkt_data = '0;
  logic [5:0]  pkt_len = '0;
  logic        pkt_var = 1'b0;
  logic        pkt_last = 1'b0;
  logic        pkt_ready, mcko;
  logic [11:0] mdo;
  logic [1:0]  mseo;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit msg_open = 0;
  bit wide_tb = 0;
  logic [13:0] exp_q[$];

  trace_msg_port dut (
    .clk(clk), .rst_n(rst_n), .clk_locked(clk_locked), .cfg_wide(cfg_wide),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_len(pkt_len), .pkt_var(pkt_var),
    .pkt_last(pkt_last), .pkt_ready(pkt_ready), .mcko(mcko), .mdo(mdo), .mseo(mseo)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] c, input logic [11:0] d);
    exp_q.push_back({c, d});
  endtask

  // Driver: computes the expected beats from the requirements, then offers the packet.
  task automatic send_pkt(input logic [31:0] data, input int len, input bit v, input bit l);
    logic [63:0] m;
    int eff, w, nb;
    logic [11:0] b;
    m = '0;
    for (int i = 0; i < len; i++) m[i] = data[i];
    if (v) begin
      eff = 0;
      for (int i = 0; i < 64; i++) if (m[i]) eff = i + 1;
      if (eff == 0) eff = 1;
    end else eff = len;
    w  = wide_tb ? 12 : 4;
    nb = (eff + w - 1) / w;
    for (int i = 0; i < nb; i++) begin
      b = 12'((m >> (i * w)) & ((64'd1 << w) - 1));
      if (i == 0 && !msg_open) begin
        push(2'b00, b);
        msg_open = 1;
        if (nb == 1 && (v || l)) push(l ? 2'b11 : 2'b01, 12'h000);
      end else if (i == nb - 1) push(l ? 2'b11 : (v ? 2'b01 : 2'b10), b);
      else push(2'b10, b);
    end
    if (l) msg_open = 0;
    pkt_valid = 1'b1;
    pkt_data  = data;
    pkt_len   = 6'(len);
    pkt_var   = v;
    pkt_last  = l;
    while (!pkt_ready) @(negedge clk);
    @(negedge clk);
    check(!pkt_ready, "R10 ready low after accept", {31'd0, pkt_ready}, 32'd0);
    if (l) pkt_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Monitor: samples at the rising edge of the message clock.
  logic [1:0] prev1 = 2'b11, prev2 = 2'b11;
  bit mon_in_msg = 0;
  always @(posedge mcko) begin
    logic [13:0] e;
    #1;
    if (!mon_in_msg && mseo == 2'b11 && mdo == 12'h000) begin
      // idle beat (R9)
    end else if (exp_q.size() == 0) begin
      check(1'b0, "R6 unexpected beat", {18'd0, mseo, mdo}, 32'd0);
    end else begin
      e = exp_q.pop_front();
      check(mdo == e[11:0], "R4 beat data", {20'd0, mdo}, {20'd0, e[11:0]});
      check(mseo == e[13:12], "R6 framing code", {30'd0, mseo}, {30'd0, e[13:12]});
      if (!wide_tb) check(mdo[11:4] == 8'h00, "R3 narrow upper bits", {24'd0, mdo[11:4]}, 32'd0);
      if (mseo == 2'b00)
        check(prev1 == 2'b11 && prev2 == 2'b11, "R8 idle gap before start",
              {28'd0, prev2, prev1}, 32'hF);
      mon_in_msg = (e[13:12] != 2'b11);
    end
    prev2 = prev1;
    prev1 = mseo;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(mdo == 12'h001 && mseo == 2'b11, "R1 during reset", {18'd0, mseo, mdo}, 32'h3001);
    check(!mcko && !pkt_ready, "R1 clock and ready during reset", {30'd0, mcko, pkt_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(mdo == 12'h001 && mseo == 2'b11, "R1 awaiting lock", {18'd0, mseo, mdo}, 32'h3001);
    check(!mcko && !pkt_ready, "R1 clock idle before lock", {30'd0, mcko, pkt_ready}, 32'd0);
    clk_locked = 1'b1;
    repeat (3) @(negedge clk);
    check(mdo == 12'h000 && mseo == 2'b11, "R9 idle after lock", {18'd0, mseo, mdo}, 32'h3000);
    for (int i = 0; i < 4; i++) begin
      logic p;
      p = mcko;
      @(negedge clk);
      check(mcko != p, "R2 message clock toggles", {31'd0, mcko}, {31'd0, !p});
    end

    // Narrow bus: padding, ignored upper bits, trimming (R3 R4 R5 R6)
    send_pkt(32'hFFFF_FFFF, 6, 0, 0);
    send_pkt(32'h0000_00F3, 32, 1, 0);
    send_pkt(32'h0000_0ABC, 12, 0, 1);
    // Zero variable single packet: extra end beat (R5 R7)
    send_pkt(32'h0000_0000, 16, 1, 1);
    drain();

    // Wide bus
    cfg_wide = 1'b1;
    wide_tb = 1;
    send_pkt(32'h0012_3456, 24, 0, 0);
    send_pkt(32'h0000_0005, 20, 1, 0);
    send_pkt(32'h0FFF_FFFF, 28, 1, 1);
    // Single-beat variable first packet: extra 01 beat (R7)
    send_pkt(32'h0000_0007, 8, 1, 0);
    send_pkt(32'h0000_0009, 4, 0, 1);
    // Single fixed final packet: extra 11 beat (R7)
    send_pkt(32'h0000_0A5A, 12, 0, 1);
    send_pkt(32'h0001_0000, 32, 1, 1);
    drain();

    // Back to narrow: one message spanning many beats
    cfg_wide = 1'b0;
    wide_tb = 0;
    send_pkt(32'h8765_4321, 32, 0, 0);
    send_pkt(32'hF000_0001, 30, 1, 1);
    drain();

    check(exp_q.size() == 0, "R6 all beats seen", exp_q.size(), 32'd0);
    check(mdo == 12'h000 && mseo == 2'b11, "R9 idle at end", {18'd0, mseo, mdo}, 32'h3000);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule